// File: doc/BRIEF.md
# Transposing Multi-Port Vector Register File

This block is a vector register file of 32 entries, each 256 bits wide, with three independent read ports and one write port. Every entry is treated as four 64-bit lanes: lane i sits at bits [64i+63 : 64i]. Beside ordinary row access, each port can reach across a group of four consecutive entries that starts at a base address that is a multiple of four. This moves data column-wise as part of the access itself, so a 4×4 transpose of 64-bit elements needs no separate rearrangement pass.

A read port in transpose mode gathers one chosen lane (the column) from each of the four entries of the group and packs them as lanes 0 to 3 of its result. The write port in transpose mode scatters the four lanes of its write vector into one chosen lane of the four entries of the group. A full transposed store therefore takes four write cycles, one per destination column. Reads are combinational from the storage array. Writes take effect at the rising clock edge. A transpose access whose base is not a multiple of four is flagged and suppressed.

Top module: `shuffle_regfile`

## Requirements
- R1: While rst is high at a rising edge, every entry is cleared to zero. After reset, every row read on any port returns zero.
- R2: A row-mode write (mode 0) with wr_en high stores wr_data into entry wr_addr at the rising edge. A row read of that entry returns it from the next cycle on.
- R3: The three read ports work independently. In the same cycle they may use different addresses, modes and columns, and each returns its own result.
- R4: Read data is combinational. A change of a read port's address, mode or column alters rd_data without any clock edge.
- R5: A read of an entry that is written in the same cycle returns the old contents. The new value appears in the cycle after the edge.
- R6: A transpose read (mode 1) with base B (a multiple of 4) and column c returns, in lane i, lane c of entry B+i, for i = 0..3. rd_err stays low.
- R7: A transpose write (mode 1) with base B and column c stores lane i of wr_data into lane c of entry B+i, for i = 0..3. All other lanes of those entries and all other entries are left unchanged.
- R8: A transpose read whose address is not a multiple of 4 raises that port's rd_err and returns all zeros.
- R9: A transpose write whose address is not a multiple of 4 raises wr_err while wr_en is high. No entry changes.
- R10: With wr_en low, no entry changes, whatever the other write inputs are.
- R11: Four transpose writes to base B, with columns 0, 1, 2 and 3 carrying row vectors V0..V3, leave entry B+i holding lane i of V0..V3 as its lanes 0..3. Together they form a full 4×4 transpose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, clears the array |
| wr_en | input | 1 | Write enable |
| wr_mode | input | 1 | Write mode: 0 row, 1 transpose |
| wr_addr | input | 5 | Write entry (row mode) or group base (transpose mode) |
| wr_col | input | 2 | Destination lane in transpose mode |
| wr_data | input | 256 | Write vector, four 64-bit lanes |
| wr_err | output | 1 | Misaligned transpose write, access suppressed |
| rd_addr | input | 3×5 | Per-port entry or group base |
| rd_mode | input | 3 | Per-port mode: 0 row, 1 transpose |
| rd_col | input | 3×2 | Per-port source lane in transpose mode |
| rd_data | output | 3×256 | Per-port read vector |
| rd_err | output | 3 | Per-port misaligned transpose read flag |

## Verification
Directed sequences come first. Known rows are written and then gathered column by column, which tells a correct lane pick apart from a swapped entry or lane index. Four transposed stores are followed by row reads, which shows whether scattered lanes land in the right entry and leave their neighbours intact. Same-entry read-and-write cycles separate old-data from write-through behaviour. Misaligned bases and idle writes with live data show whether suppression really blocks the array. A seeded random mix of modes, bases, columns and enables on all three ports then compares every port in every cycle against a bench model. This exposes cross-port interference and corner combinations the directed cases miss.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

    typedef enum logic {
        ACC_ROW   = 1'b0,
        ACC_XPOSE = 1'b1
    } acc_mode_e;

    // True when an address starts a group of 'group' consecutive entries.
    function automatic logic grp_aligned(input int unsigned addr, input int unsigned group);
        return (addr % group) == 0;
    endfunction

endpackage

// File: rtl/vrf_write_unit.sv
module vrf_write_unit
    import vrf_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int LANES   = 4,
    parameter int LANE_W  = 64,
    parameter int AW      = 5,
    parameter int LSEL    = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  acc_mode_e                         wr_mode,
    input  logic [AW-1:0]                     wr_addr,
    input  logic [LSEL-1:0]                   wr_col,
    input  logic [LANES*LANE_W-1:0]           wr_data,
    output logic [ENTRIES-1:0][LANES-1:0]     lane_we,
    output logic [ENTRIES-1:0][LANES*LANE_W-1:0] ent_data,
    output logic                              wr_err
);
    logic misalign;

    assign misalign = (wr_mode == ACC_XPOSE) && !grp_aligned(32'(wr_addr), LANES);
    assign wr_err   = wr_en && misalign;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        localparam logic [AW-1:0] EA = AW'(e);
        logic row_hit;
        logic grp_hit;

        assign row_hit = wr_en && (wr_mode == ACC_ROW) && (wr_addr == EA);
        assign grp_hit = wr_en && (wr_mode == ACC_XPOSE) && !misalign
                         && (wr_addr[AW-1:LSEL] == EA[AW-1:LSEL]);

        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign lane_we[e][l] = row_hit || (grp_hit && (wr_col == LSEL'(l)));
            // Row mode keeps lanes in place; transpose sends lane (e mod LANES) of the vector.
            assign ent_data[e][l*LANE_W +: LANE_W] = (wr_mode == ACC_ROW)
                ? wr_data[l*LANE_W +: LANE_W]
                : wr_data[(e % LANES)*LANE_W +: LANE_W];
        end

        assert_xpose_single_lane_R7: assert property (@(posedge clk) disable iff (rst)
            (wr_mode == ACC_XPOSE) |-> ($countones(lane_we[e]) <= 1));
    end

    assert_bad_wr_no_mask_R9: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> (lane_we == '0));

endmodule

// File: rtl/vrf_array.sv
module vrf_array #(
    parameter int ENTRIES = 32,
    parameter int LANES   = 4,
    parameter int LANE_W  = 64
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [ENTRIES-1:0][LANES-1:0]        lane_we,
    input  logic [ENTRIES-1:0][LANES*LANE_W-1:0] ent_data,
    output logic [ENTRIES-1:0][LANES*LANE_W-1:0] mem_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                for (int l = 0; l < LANES; l++) begin
                    if (lane_we[e][l]) begin
                        mem_q[e][l*LANE_W +: LANE_W] <= ent_data[e][l*LANE_W +: LANE_W];
                    end
                end
            end
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
        assert_cleared_R1: assert property (@(posedge clk)
            $past(rst) |-> (mem_q[e] == '0));

        assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
            (lane_we[e] == '0) |=> $stable(mem_q[e]));

        for (genvar l = 0; l < LANES; l++) begin : g_lchk
            assert_lane_store_R2: assert property (@(posedge clk) disable iff (rst)
                lane_we[e][l] |=> (mem_q[e][l*LANE_W +: LANE_W]
                                   == $past(ent_data[e][l*LANE_W +: LANE_W])));
        end
    end

endmodule

// File: rtl/vrf_read_port.sv
module vrf_read_port
    import vrf_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int LANES   = 4,
    parameter int LANE_W  = 64,
    parameter int AW      = 5,
    parameter int LSEL    = 2
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [ENTRIES-1:0][LANES*LANE_W-1:0] mem_q,
    input  logic [AW-1:0]                        rd_addr,
    input  acc_mode_e                            rd_mode,
    input  logic [LSEL-1:0]                      rd_col,
    output logic [LANES*LANE_W-1:0]              rd_data,
    output logic                                 rd_err
);
    always_comb begin
        rd_err  = (rd_mode == ACC_XPOSE) && !grp_aligned(32'(rd_addr), LANES);
        rd_data = '0;
        if (rd_mode == ACC_ROW) begin
            rd_data = mem_q[rd_addr];
        end else if (!rd_err) begin
            // Gather lane rd_col from each entry of the group.
            for (int i = 0; i < LANES; i++) begin
                rd_data[i*LANE_W +: LANE_W] =
                    mem_q[{rd_addr[AW-1:LSEL], LSEL'(i)}][int'(rd_col)*LANE_W +: LANE_W];
            end
        end
    end

    assert_misalign_zero_R8: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> (rd_data == '0));

endmodule

// File: rtl/shuffle_regfile.sv
module shuffle_regfile
    import vrf_pkg::*;
#(
    parameter int ENTRIES  = 32,
    parameter int LANES    = 4,
    parameter int LANE_W   = 64,
    parameter int RD_PORTS = 3
) (
    input  logic                                            clk,
    input  logic                                            rst,
    input  logic                                            wr_en,
    input  logic                                            wr_mode,
    input  logic [$clog2(ENTRIES)-1:0]                      wr_addr,
    input  logic [$clog2(LANES)-1:0]                        wr_col,
    input  logic [LANES*LANE_W-1:0]                         wr_data,
    output logic                                            wr_err,
    input  logic [RD_PORTS-1:0][$clog2(ENTRIES)-1:0]        rd_addr,
    input  logic [RD_PORTS-1:0]                             rd_mode,
    input  logic [RD_PORTS-1:0][$clog2(LANES)-1:0]          rd_col,
    output logic [RD_PORTS-1:0][LANES*LANE_W-1:0]           rd_data,
    output logic [RD_PORTS-1:0]                             rd_err
);
    localparam int AW    = $clog2(ENTRIES);
    localparam int LSEL  = $clog2(LANES);
    localparam int WIDTH = LANES * LANE_W;

    logic [ENTRIES-1:0][LANES-1:0] lane_we;
    logic [ENTRIES-1:0][WIDTH-1:0] ent_data;
    logic [ENTRIES-1:0][WIDTH-1:0] mem_q;

    vrf_write_unit #(
        .ENTRIES(ENTRIES), .LANES(LANES), .LANE_W(LANE_W), .AW(AW), .LSEL(LSEL)
    ) i_wr (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_mode  (acc_mode_e'(wr_mode)),
        .wr_addr  (wr_addr),
        .wr_col   (wr_col),
        .wr_data  (wr_data),
        .lane_we  (lane_we),
        .ent_data (ent_data),
        .wr_err   (wr_err)
    );

    vrf_array #(
        .ENTRIES(ENTRIES), .LANES(LANES), .LANE_W(LANE_W)
    ) i_arr (
        .clk      (clk),
        .rst      (rst),
        .lane_we  (lane_we),
        .ent_data (ent_data),
        .mem_q    (mem_q)
    );

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        vrf_read_port #(
            .ENTRIES(ENTRIES), .LANES(LANES), .LANE_W(LANE_W), .AW(AW), .LSEL(LSEL)
        ) i_rp (
            .clk     (clk),
            .rst     (rst),
            .mem_q   (mem_q),
            .rd_addr (rd_addr[p]),
            .rd_mode (acc_mode_e'(rd_mode[p])),
            .rd_col  (rd_col[p]),
            .rd_data (rd_data[p]),
            .rd_err  (rd_err[p])
        );
    end

endmodule

// File: tb/test_shuffle_regfile.sv
`timescale 1ns/1ps
module test_shuffle_regfile;
    localparam int N  = 32;
    localparam int NL = 4;
    localparam int LW = 64;
    localparam int W  = NL*LW;
    localparam int RP = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic wr_mode = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [1:0] wr_col = '0;
    logic [W-1:0] wr_data = '0;
    logic wr_err;
    logic [RP-1:0][4:0] rd_addr = '0;
    logic [RP-1:0] rd_mode = '0;
    logic [RP-1:0][1:0] rd_col = '0;
    logic [RP-1:0][W-1:0] rd_data;
    logic [RP-1:0] rd_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [W-1:0] ref_mem [N];

    always #2.5 clk = ~clk;

    shuffle_regfile i_shuffle_regfile (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mode(wr_mode), .wr_addr(wr_addr),
        .wr_col(wr_col), .wr_data(wr_data), .wr_err(wr_err), .rd_addr(rd_addr),
        .rd_mode(rd_mode), .rd_col(rd_col), .rd_data(rd_data), .rd_err(rd_err)
    );

    function automatic logic [W-1:0] rand_vec();
        logic [W-1:0] v;
        for (int k = 0; k < W/32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic exp_err(input logic [4:0] a, input logic m);
        return m && (a[1:0] != 2'b00);
    endfunction

    function automatic logic [W-1:0] exp_data(input logic [4:0] a, input logic m, input logic [1:0] c);
        logic [W-1:0] v;
        v = '0;
        if (!m) v = ref_mem[a];
        else if (a[1:0] == 2'b00)
            for (int i = 0; i < NL; i++) v[i*LW +: LW] = ref_mem[{a[4:2], 2'(i)}][int'(c)*LW +: LW];
        return v;
    endfunction

    function automatic void model_write();
        if (!wr_en) return;
        if (!wr_mode) ref_mem[wr_addr] = wr_data;
        else if (wr_addr[1:0] == 2'b00)
            for (int i = 0; i < NL; i++) ref_mem[{wr_addr[4:2], 2'(i)}][int'(wr_col)*LW +: LW] = wr_data[i*LW +: LW];
    endfunction

    task automatic check_port(input int p, input string tag);
        logic [W-1:0] ed;
        logic ee;
        ed = exp_data(rd_addr[p], rd_mode[p], rd_col[p]);
        ee = exp_err(rd_addr[p], rd_mode[p]);
        checks++;
        if (rd_data[p] !== ed || rd_err[p] !== ee) begin
            errors++;
            $display("FAIL %s port %0d: data %h err %b, expected data %h err %b",
                     tag, p, rd_data[p], rd_err[p], ed, ee);
        end
    endtask

    task automatic check_all(input string tag);
        #1;
        for (int p = 0; p < RP; p++) check_port(p, tag);
        checks++;
        if (wr_err !== (wr_en && exp_err(wr_addr, wr_mode))) begin
            errors++;
            $display("FAIL %s wr_err: %b expected %b", tag, wr_err, wr_en && exp_err(wr_addr, wr_mode));
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_write();
        @(negedge clk);
    endtask

    task automatic set_wr(input logic en, input logic m, input logic [4:0] a,
                          input logic [1:0] c, input logic [W-1:0] d);
        wr_en = en; wr_mode = m; wr_addr = a; wr_col = c; wr_data = d;
    endtask

    task automatic set_rd(input int p, input logic [4:0] a, input logic m, input logic [1:0] c);
        rd_addr[p] = a; rd_mode[p] = m; rd_col[p] = c;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int e = 0; e < N; e++) ref_mem[e] = '0;
        set_wr(1'b1, 1'b0, 5'd3, 2'd0, rand_vec());
        repeat (3) @(negedge clk);
        rst = 1'b0;
        set_wr(1'b0, 1'b0, 5'd0, 2'd0, '0);

        // R1 reset clears all entries; R4 reads follow address without a clock
        for (int e = 0; e < N; e += RP) begin
            for (int p = 0; p < RP; p++) set_rd(p, 5'((e + p) % N), 1'b0, 2'd0);
            check_all("R1 R4");
        end

        // R2/R5: write and read the same entry in one cycle
        set_wr(1'b1, 1'b0, 5'd5, 2'd0, rand_vec());
        set_rd(0, 5'd5, 1'b0, 2'd0);
        set_rd(1, 5'd6, 1'b0, 2'd0);
        set_rd(2, 5'd5, 1'b1, 2'd1);
        check_all("R5 old data");
        step();
        set_wr(1'b0, 1'b0, 5'd0, 2'd0, '0);
        check_all("R5 R2 new data");

        // R6: rows 8..11 then transpose reads of every column
        for (int r = 0; r < 4; r++) begin
            set_wr(1'b1, 1'b0, 5'(8 + r), 2'd0, rand_vec());
            step();
        end
        set_wr(1'b0, 1'b0, 5'd0, 2'd0, '0);
        set_rd(0, 5'd8, 1'b1, 2'd0);
        set_rd(1, 5'd8, 1'b1, 2'd1);
        set_rd(2, 5'd8, 1'b1, 2'd2);
        check_all("R6 R3");
        set_rd(0, 5'd8, 1'b1, 2'd3);
        check_all("R6 R4 column change");

        // R11: four transpose writes to base 16, then row reads
        for (int c = 0; c < 4; c++) begin
            set_wr(1'b1, 1'b1, 5'd16, 2'(c), rand_vec());
            step();
        end
        set_wr(1'b0, 1'b0, 5'd0, 2'd0, '0);
        for (int r = 0; r < 4; r++) begin
            set_rd(0, 5'(16 + r), 1'b0, 2'd0);
            set_rd(1, 5'(16 + ((r + 1) % 4)), 1'b0, 2'd0);
            set_rd(2, 5'd16, 1'b1, 2'(r));
            check_all("R11");
        end

        // R7: single-column transpose write over filled rows 8..11
        set_wr(1'b1, 1'b1, 5'd8, 2'd2, rand_vec());
        step();
        set_wr(1'b0, 1'b0, 5'd0, 2'd0, '0);
        for (int r = 0; r < 4; r++) begin
            set_rd(0, 5'(8 + r), 1'b0, 2'd0);
            set_rd(1, 5'd12, 1'b0, 2'd0);
            set_rd(2, 5'd7, 1'b0, 2'd0);
            check_all("R7");
        end

        // R8: misaligned transpose read
        set_rd(0, 5'd13, 1'b1, 2'd1);
        set_rd(1, 5'd10, 1'b1, 2'd0);
        set_rd(2, 5'd31, 1'b1, 2'd3);
        check_all("R8");

        // R9: misaligned transpose write is flagged and blocked
        set_wr(1'b1, 1'b1, 5'd9, 2'd1, rand_vec());
        check_all("R9 flag");
        step();
        set_wr(1'b0, 1'b0, 5'd0, 2'd0, '0);
        for (int r = 0; r < 4; r++) begin
            set_rd(0, 5'(8 + r), 1'b0, 2'd0);
            set_rd(1, 5'd8, 1'b1, 2'(r));
            set_rd(2, 5'(12 + r), 1'b0, 2'd0);
            check_all("R9 unchanged");
        end

        // R10: idle write inputs with live data
        set_wr(1'b0, 1'b0, 5'd5, 2'd0, rand_vec());
        step();
        set_wr(1'b0, 1'b1, 5'd16, 2'd1, rand_vec());
        step();
        set_rd(0, 5'd5, 1'b0, 2'd0);
        set_rd(1, 5'd16, 1'b0, 2'd0);
        set_rd(2, 5'd17, 1'b0, 2'd0);
        check_all("R10");

        // Random mix on all ports (R2 R3 R5 R6 R7 R8 R9 R10)
        for (int it = 0; it < 600; it++) begin
            set_wr(($urandom % 4) != 0, ($urandom % 3) == 0, 5'($urandom), 2'($urandom), rand_vec());
            for (int p = 0; p < RP; p++) begin
                logic m;
                logic [4:0] a;
                m = ($urandom % 3) == 0;
                a = 5'($urandom);
                if (m && ($urandom % 2) == 0) a[1:0] = 2'b00;
                set_rd(p, a, m, 2'($urandom));
            end
            if (($urandom % 4) == 0 && !wr_mode) set_rd(0, wr_addr, 1'b0, 2'd0);
            check_all("R3 random");
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule